// File: doc/BRIEF.md
# Two-Road Crossing Signal Controller

This block sequences the signal lamps at a junction of two roads, called road A and road B. Each road has a presence sensor that is high while vehicles wait or move on it. The road that holds the right of way keeps a green lamp for as long as its own sensor stays high. When that sensor is seen low on a rising clock edge, the road's lamp turns yellow for a single clock period. The right of way then passes to the other road, which follows the same rule.

The controller is a Moore machine with four phases. The lamp outputs depend only on the phase. Both lamp outputs are registered, and each is loaded from the phase that the machine is about to enter, so a lamp changes on the same rising edge as the phase it belongs to. The system clock period is chosen to equal the required yellow time. Reset is synchronous and active high, and it returns the junction to road A green.

Top module: `crossing_signal_ctrl`

## Requirements
- R1: On the first rising edge at which `rst` is sampled high, `lamp_a` becomes green and `lamp_b` becomes red. Both stay that way on every edge while `rst` remains high.
- R2: While road A shows green and `sense_a` is sampled high, road A stays green and road B stays red.
- R3: When `sense_a` is sampled low while road A shows green, the next edge turns `lamp_a` yellow and keeps `lamp_b` red.
- R4: Road A's yellow lasts exactly one clock period. The following edge always sets `lamp_a` red and `lamp_b` green, whatever the sensor values are.
- R5: While road B shows green and `sense_b` is sampled high, road B stays green and road A stays red.
- R6: When `sense_b` is sampled low while road B shows green, `lamp_b` turns yellow for exactly one period. The edge after that always returns to `lamp_a` green and `lamp_b` red.
- R7: Lamp encoding is green = 2'b00, yellow = 2'b01 and red = 2'b10. The code 2'b11 never appears on either lamp output.
- R8: On every cycle after reset, exactly one of the two lamp outputs is red.
- R9: `sense_b` has no effect while road A shows green or yellow, and `sense_a` has no effect while road B shows green or yellow.
- R10: Reset takes priority over every transition, including a transition out of a yellow phase or out of road B's green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its period equals the yellow time |
| rst | input | 1 | Synchronous active-high reset |
| sense_a | input | 1 | High while vehicles are present on road A |
| sense_b | input | 1 | High while vehicles are present on road B |
| lamp_a | output | 2 | Road A lamp: 00 green, 01 yellow, 10 red |
| lamp_b | output | 2 | Road B lamp: 00 green, 01 yellow, 10 red |

## Verification
The bench drives the sensor of the road that does not hold the right of way high, and keeps the waiting road's sensor high during a yellow phase. A design that listened to the wrong sensor would cut a green short, or would stretch a yellow past one period. The bench also asserts reset in the middle of a yellow phase and in the middle of road B's green. A design that gave a transition priority over reset would then leave the junction in a phase other than road A green. Each step also checks that exactly one road is red, which catches decodes that show two greens at once or that emit the unused lamp code.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int PHASE_W = 2;
  localparam int LAMP_W  = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_A_GO   = 2'b00,
    PH_A_WARN = 2'b01,
    PH_B_GO   = 2'b10,
    PH_B_WARN = 2'b11
  } phase_t;

  typedef enum logic [LAMP_W-1:0] {
    LAMP_GREEN  = 2'b00,
    LAMP_YELLOW = 2'b01,
    LAMP_RED    = 2'b10
  } lamp_t;
endpackage

// File: rtl/xs_phase_fsm.sv
module xs_phase_fsm
  import xs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sense_a,
  input  logic   sense_b,
  output phase_t phase_q,
  output phase_t phase_d
);
  // next-phase logic: only the owning road's sensor is consulted (R9)
  always_comb begin
    phase_d = PH_A_GO;
    if (rst) begin
      phase_d = PH_A_GO;                                  // R10
    end else begin
      case (phase_q)
        PH_A_GO:   phase_d = sense_a ? PH_A_GO : PH_A_WARN; // R2, R3
        PH_A_WARN: phase_d = PH_B_GO;                       // R4
        PH_B_GO:   phase_d = sense_b ? PH_B_GO : PH_B_WARN; // R5, R6
        PH_B_WARN: phase_d = PH_A_GO;                       // R6
        default:   phase_d = PH_A_GO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase_q <= phase_d;
  end

  // a yellow phase never lasts more than one period
  p_a_warn_once_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_A_WARN) |=> (phase_q != PH_A_WARN));
  p_b_warn_once_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_B_WARN) |=> (phase_q != PH_B_WARN));
endmodule

// File: rtl/xs_lamp_decode.sv
module xs_lamp_decode
  import xs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_nxt,
  output lamp_t  lamp_a_q,
  output lamp_t  lamp_b_q
);
  lamp_t lamp_a_d;
  lamp_t lamp_b_d;

  // Moore decode of the upcoming phase, so registered lamps align with the phase
  always_comb begin
    lamp_a_d = LAMP_RED;
    lamp_b_d = LAMP_RED;
    case (phase_nxt)
      PH_A_GO:   begin lamp_a_d = LAMP_GREEN;  lamp_b_d = LAMP_RED;    end
      PH_A_WARN: begin lamp_a_d = LAMP_YELLOW; lamp_b_d = LAMP_RED;    end
      PH_B_GO:   begin lamp_a_d = LAMP_RED;    lamp_b_d = LAMP_GREEN;  end
      PH_B_WARN: begin lamp_a_d = LAMP_RED;    lamp_b_d = LAMP_YELLOW; end
      default:   begin lamp_a_d = LAMP_RED;    lamp_b_d = LAMP_RED;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lamp_a_q <= LAMP_GREEN;
      lamp_b_q <= LAMP_RED;
    end else begin
      lamp_a_q <= lamp_a_d;
      lamp_b_q <= lamp_b_d;
    end
  end
endmodule

// File: rtl/crossing_signal_ctrl.sv
module crossing_signal_ctrl
  import xs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_a,
  input  logic              sense_b,
  output logic [LAMP_W-1:0] lamp_a,
  output logic [LAMP_W-1:0] lamp_b
);
  phase_t phase_q;
  phase_t phase_d;
  lamp_t  lamp_a_q;
  lamp_t  lamp_b_q;

  xs_phase_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .phase_q (phase_q),
    .phase_d (phase_d)
  );

  xs_lamp_decode u_lamps (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_d),
    .lamp_a_q  (lamp_a_q),
    .lamp_b_q  (lamp_b_q)
  );

  assign lamp_a = lamp_a_q;
  assign lamp_b = lamp_b_q;

  // lamps follow the phase register
  p_lamp_tracks_phase_r1: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_A_GO) |-> (lamp_a == LAMP_GREEN && lamp_b == LAMP_RED));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (lamp_a == LAMP_GREEN && lamp_b == LAMP_RED));

  p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == LAMP_GREEN && sense_a) |=> (lamp_a == LAMP_GREEN && lamp_b == LAMP_RED));

  p_a_yellow_r3: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == LAMP_GREEN && !sense_a) |=> (lamp_a == LAMP_YELLOW && lamp_b == LAMP_RED));

  p_a_handover_r4: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == LAMP_YELLOW) |=> (lamp_a == LAMP_RED && lamp_b == LAMP_GREEN));

  p_hold_b_r5: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == LAMP_GREEN && sense_b) |=> (lamp_b == LAMP_GREEN && lamp_a == LAMP_RED));

  p_b_yellow_r6: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == LAMP_GREEN && !sense_b) |=> (lamp_b == LAMP_YELLOW && lamp_a == LAMP_RED));

  p_b_handover_r6: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == LAMP_YELLOW) |=> (lamp_a == LAMP_GREEN && lamp_b == LAMP_RED));

  p_no_bad_code_r7: assert property (@(posedge clk) disable iff (rst)
    (lamp_a != 2'b11) && (lamp_b != 2'b11));

  p_one_red_r8: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == LAMP_RED) != (lamp_b == LAMP_RED));
endmodule

// File: tb/crossing_signal_ctrl_test.sv
`timescale 1ns/1ps
module crossing_signal_ctrl_test;
  localparam logic [1:0] G = 2'b00;
  localparam logic [1:0] Y = 2'b01;
  localparam logic [1:0] RD = 2'b10;
  localparam int NVEC = 21;

  // {rst, sense_a, sense_b, expected lamp_a, expected lamp_b} after the edge
  localparam logic [6:0] VEC [0:NVEC-1] = '{
    {3'b100, G,  RD},  // 0  R1 reset
    {3'b010, G,  RD},  // 1  R2 hold
    {3'b011, G,  RD},  // 2  R9 sense_b ignored in A green
    {3'b010, G,  RD},  // 3  R2
    {3'b000, Y,  RD},  // 4  R3
    {3'b010, RD, G },  // 5  R4 sense_a high does not extend yellow
    {3'b001, RD, G },  // 6  R5
    {3'b011, RD, G },  // 7  R9 sense_a ignored in B green
    {3'b010, RD, Y },  // 8  R6 yellow
    {3'b001, G,  RD},  // 9  R6 return, sense_b ignored
    {3'b001, Y,  RD},  // 10 R3
    {3'b000, RD, G },  // 11 R4
    {3'b000, RD, Y },  // 12 R6
    {3'b000, G,  RD},  // 13 R6
    {3'b000, Y,  RD},  // 14 R3
    {3'b100, G,  RD},  // 15 R10 reset beats yellow exit
    {3'b010, G,  RD},  // 16 R2
    {3'b000, Y,  RD},  // 17 R3
    {3'b001, RD, G },  // 18 R4
    {3'b101, G,  RD},  // 19 R10 reset beats B green
    {3'b011, G,  RD}   // 20 R2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sense_a = 1'b0;
  logic sense_b = 1'b0;
  logic [1:0] lamp_a;
  logic [1:0] lamp_b;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  crossing_signal_ctrl uut (
    .clk     (clk),
    .rst     (rst),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .lamp_a  (lamp_a),
    .lamp_b  (lamp_b)
  );

  task automatic step(input logic r, input logic sa, input logic sb);
    @(negedge clk);
    rst = r; sense_a = sa; sense_b = sb;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_lamps(input string req, input logic [1:0] ea, input logic [1:0] eb);
    checks++;
    if (lamp_a !== ea || lamp_b !== eb) begin
      fails++;
      $display("FAIL %s: lamps a=%b b=%b expected a=%b b=%b", req, lamp_a, lamp_b, ea, eb);
    end
    checks++;  // R7 / R8 on every step
    if ((lamp_a == 2'b11) || (lamp_b == 2'b11) || ((lamp_a == RD) == (lamp_b == RD))) begin
      fails++;
      $display("FAIL R7/R8: lamps a=%b b=%b expected legal codes with exactly one red", lamp_a, lamp_b);
    end
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4]);
      expect_lamps($sformatf("vector %0d (R1..R10 table)", i), VEC[i][3:2], VEC[i][1:0]);
    end

    // R2: long hold on road A with road B traffic present (R9)
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b1, 1'b1);
      expect_lamps("R2 long hold", G, RD);
    end
    // R5: move to B and hold it long
    step(1'b0, 1'b0, 1'b1); expect_lamps("R3", Y, RD);
    step(1'b0, 1'b0, 1'b1); expect_lamps("R4", RD, G);
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b1, 1'b1);
      expect_lamps("R5 long hold", RD, G);
    end
    // R10: reset during B yellow, held several cycles with sensors idle
    step(1'b0, 1'b1, 1'b0); expect_lamps("R6", RD, Y);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 1'b0);
      expect_lamps("R10 held reset", G, RD);
    end
    // R1 after reset release: road A green held, then yellow on drop
    step(1'b0, 1'b1, 1'b0); expect_lamps("R1", G, RD);
    step(1'b0, 1'b0, 1'b0); expect_lamps("R3", Y, RD);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule